// File: doc/BRIEF.md
# Vector Load Address Generator

This block walks through the element and segment space of one vector load and issues, one per cycle, the memory byte address of every access the load needs. A single command sets the base address, the element size in bytes, a choice between unit stride (the stride equals the element size) and a constant stride taken from a scalar register value, an indexed flag, a segment count, the vector length and a predicate mask that may be enabled and inverted. For each active element and each of its segments the block presents the address together with the destination register and the element number the returned data belongs to.

Accesses leave over a valid/ready handshake. Elements go in ascending order and, within an element, the segment index runs fastest. In indexed mode the caller supplies, on a separate input, the per-element offset of the element currently shown on the element output, which replaces the computed element offset. Memory requests and returned data are handled elsewhere. All address arithmetic wraps at the address width and raises no fault.

Top module: `vld_agen`

## Requirements
- R1: While reset is held low and on the first cycle after its release, `busy` and `addr_valid` are 0.
- R2: With `stride_mode` = 0 (unit) and `indexed` = 0, the access for element i and segment j is at base + i*(seg_len+1)*elem_bytes + j*elem_bytes.
- R3: With `stride_mode` = 1 (constant) and `indexed` = 0, the same formula holds with `stride_val` in place of `elem_bytes`.
- R4: With `indexed` = 1, the access for element i and segment j is at base + idx_offset + j*stride, where idx_offset is the value driven while `dst_elem` shows i and the stride follows R2 or R3.
- R5: Each active element produces exactly seg_len+1 accesses with the segment index as the inner loop; access j carries `dst_reg` = rd + j modulo 2^RD_W and `dst_elem` = i.
- R6: With `pred_en` = 1, element i is active only when `pred_mask[i]` XOR `pred_inv` is 1; active elements go out in ascending order.
- R7: With `pred_en` = 0, every element 0 to vl-1 is active.
- R8: While `addr_valid` is 1 and `addr_ready` is 0, `addr_valid`, `addr`, `dst_reg` and `dst_elem` hold; one access is consumed per cycle with both high.
- R9: Address sums wrap modulo 2^AW.
- R10: A command is taken when `start` is 1 and `busy` is 0; `start` while busy has no effect; `busy` falls on the cycle after the last access is taken, and a command with no active element (including vl = 0) leaves `busy` at 0 and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Take a new command when idle |
| base_addr | input | AW | Base byte address |
| elem_bytes | input | EB_W | Element size in bytes |
| stride_mode | input | 1 | 0 unit stride, 1 constant stride |
| stride_val | input | AW | Constant stride value |
| indexed | input | 1 | Use per-element offset input |
| idx_offset | input | AW | Offset of element shown on dst_elem |
| seg_len | input | SEG_W | Segments per element minus one |
| vl | input | VL_W | Vector length |
| rd | input | RD_W | First destination register |
| pred_en | input | 1 | Predicate mask in use |
| pred_inv | input | 1 | Invert predicate mask |
| pred_mask | input | MAX_VL | Per-element predicate bits |
| busy | output | 1 | Command in progress |
| addr_valid | output | 1 | Access offered |
| addr_ready | input | 1 | Access accepted |
| addr | output | AW | Access byte address |
| dst_reg | output | RD_W | Destination register of access |
| dst_elem | output | ELEM_W | Element number of access |

## Verification
The properties assume the command inputs (mask, vector length, enables, rd) stay unchanged while `busy` is high, and that `idx_offset` is a pure function of `dst_elem`, so a stalled access keeps a stable address. The stimulus changes command inputs only at idle points and derives the offset from a fixed table indexed by the shown element. Ready is driven both always-high and in a pseudo-random stall pattern, so the hold and ordering properties see back-pressure on every mode, including segment wrap of the register number and address wrap near the top of the space.

// File: rtl/vld_agen_pkg.sv
// Package: shared types for the vector load address generator.
// Assumes nothing beyond the two stride selections it names.
package vld_agen_pkg;
    typedef enum logic {
        STRIDE_UNIT  = 1'b0,
        STRIDE_CONST = 1'b1
    } stride_mode_e;
endpackage

// File: rtl/vld_pred_scan.sv
// Module: finds the lowest set bit of a mask at or above a start position.
// Assumes from may equal N, meaning no position remains.
module vld_pred_scan #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0] mask,
    input  logic [IW:0]  from,
    output logic         found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] cand;

    // qualify each mask bit by its position against the start point
    for (genvar g = 0; g < N; g++) begin : g_cand
        assign cand[g] = mask[g] && ((IW+1)'(g) >= from);
    end

    // lowest qualified position wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/vld_walk.sv
// Module: element/segment sequencer. Latches the active-element mask on a
// taken command, then steps segment (inner) and element (outer) on each
// accepted access. Assumes eff_mask already folds in vl and predication.
module vld_walk #(
    parameter int MAX_VL = 32,
    parameter int SEG_W  = 3,
    parameter int RD_W   = 5,
    localparam int ELEM_W = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MAX_VL-1:0] eff_mask,
    input  logic [SEG_W-1:0]  seg_len,
    input  logic [RD_W-1:0]   rd,
    input  logic              fire,
    output logic              accept,
    output logic              busy,
    output logic [ELEM_W-1:0] elem,
    output logic [SEG_W-1:0]  seg,
    output logic [RD_W-1:0]   dst_reg
);
    logic [MAX_VL-1:0] mask_q;
    logic [SEG_W-1:0]  segl_q;
    logic [RD_W-1:0]   rd_q;
    logic              first_found, next_found;
    logic [ELEM_W-1:0] first_idx, next_idx;
    logic [ELEM_W:0]   next_from;

    assign accept    = start && !busy;
    assign next_from = {1'b0, elem} + 1'b1;
    assign dst_reg   = rd_q + RD_W'(seg);

    vld_pred_scan #(.N(MAX_VL), .IW(ELEM_W)) u_first (
        .mask (eff_mask),
        .from ('0),
        .found(first_found),
        .idx  (first_idx)
    );

    vld_pred_scan #(.N(MAX_VL), .IW(ELEM_W)) u_next (
        .mask (mask_q),
        .from (next_from),
        .found(next_found),
        .idx  (next_idx)
    );

    // command capture and segment/element stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            elem   <= '0;
            seg    <= '0;
            mask_q <= '0;
            segl_q <= '0;
            rd_q   <= '0;
        end else if (accept) begin
            mask_q <= eff_mask;
            segl_q <= seg_len;
            rd_q   <= rd;
            elem   <= first_idx;
            seg    <= '0;
            busy   <= first_found;
        end else if (busy && fire) begin
            if (seg != segl_q) begin
                seg <= seg + 1'b1;
            end else if (next_found) begin
                elem <= next_idx;
                seg  <= '0;
            end else begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vld_addr_calc.sv
// Module: address arithmetic. Latches base, effective stride, segment
// count and mode on a taken command; forms the address from the current
// element and segment. Assumes idx_offset belongs to the current element.
module vld_addr_calc
    import vld_agen_pkg::*;
#(
    parameter int AW     = 32,
    parameter int EB_W   = 8,
    parameter int SEG_W  = 3,
    parameter int ELEM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     base_addr,
    input  logic [EB_W-1:0]   elem_bytes,
    input  logic              stride_mode,
    input  logic [AW-1:0]     stride_val,
    input  logic              indexed,
    input  logic [SEG_W-1:0]  seg_len,
    input  logic [AW-1:0]     idx_offset,
    input  logic [ELEM_W-1:0] elem,
    input  logic [SEG_W-1:0]  seg,
    output logic [AW-1:0]     addr
);
    logic [AW-1:0] base_q, stride_q, segn_q;
    logic          indexed_q;
    logic [AW-1:0] elem_off;
    stride_mode_e  mode;

    assign mode = stride_mode_e'(stride_mode);

    // capture per-command address terms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            stride_q  <= '0;
            segn_q    <= '0;
            indexed_q <= 1'b0;
        end else if (load) begin
            base_q    <= base_addr;
            stride_q  <= (mode == STRIDE_CONST) ? stride_val : AW'(elem_bytes);
            segn_q    <= AW'(seg_len) + 1'b1;
            indexed_q <= indexed;
        end
    end

    // element offset then final wrapping sum
    always_comb begin
        elem_off = indexed_q ? idx_offset : (AW'(elem) * segn_q * stride_q);
        addr     = base_q + elem_off + (AW'(seg) * stride_q);
    end
endmodule

// File: rtl/vld_agen.sv
// Module: top of the vector load address generator. Folds vl and the
// predicate controls into an active-element mask, runs the sequencer and
// the address arithmetic, and offers one access per cycle on valid/ready.
// Assumes command inputs are held while busy.
module vld_agen #(
    parameter int AW     = 32,
    parameter int EB_W   = 8,
    parameter int MAX_VL = 32,
    parameter int SEG_W  = 3,
    parameter int RD_W   = 5,
    localparam int ELEM_W = $clog2(MAX_VL),
    localparam int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_addr,
    input  logic [EB_W-1:0]   elem_bytes,
    input  logic              stride_mode,
    input  logic [AW-1:0]     stride_val,
    input  logic              indexed,
    input  logic [AW-1:0]     idx_offset,
    input  logic [SEG_W-1:0]  seg_len,
    input  logic [VL_W-1:0]   vl,
    input  logic [RD_W-1:0]   rd,
    input  logic              pred_en,
    input  logic              pred_inv,
    input  logic [MAX_VL-1:0] pred_mask,
    output logic              busy,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [AW-1:0]     addr,
    output logic [RD_W-1:0]   dst_reg,
    output logic [ELEM_W-1:0] dst_elem
);
    logic [MAX_VL-1:0] eff_mask;
    logic              accept;
    logic [SEG_W-1:0]  seg;

    // per-element activity: inside vl and passing the optional predicate
    for (genvar g = 0; g < MAX_VL; g++) begin : g_act
        assign eff_mask[g] = (VL_W'(g) < vl) && (!pred_en || (pred_mask[g] ^ pred_inv));
    end

    assign addr_valid = busy;

    vld_walk #(.MAX_VL(MAX_VL), .SEG_W(SEG_W), .RD_W(RD_W)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .eff_mask(eff_mask),
        .seg_len (seg_len),
        .rd      (rd),
        .fire    (addr_ready),
        .accept  (accept),
        .busy    (busy),
        .elem    (dst_elem),
        .seg     (seg),
        .dst_reg (dst_reg)
    );

    vld_addr_calc #(.AW(AW), .EB_W(EB_W), .SEG_W(SEG_W), .ELEM_W(ELEM_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .base_addr  (base_addr),
        .elem_bytes (elem_bytes),
        .stride_mode(stride_mode),
        .stride_val (stride_val),
        .indexed    (indexed),
        .seg_len    (seg_len),
        .idx_offset (idx_offset),
        .elem       (dst_elem),
        .seg        (seg),
        .addr       (addr)
    );
endmodule

// File: rtl/vld_agen_chk.sv
// Module: property checker for vld_agen, attached by bind below.
// Assumes command inputs are stable while busy and idx_offset depends
// only on dst_elem.
module vld_agen_chk #(
    parameter int AW     = 32,
    parameter int MAX_VL = 32,
    parameter int RD_W   = 5,
    parameter int ELEM_W = 5,
    parameter int VL_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [AW-1:0]     addr,
    input logic [RD_W-1:0]   dst_reg,
    input logic [ELEM_W-1:0] dst_elem,
    input logic [VL_W-1:0]   vl,
    input logic              pred_en,
    input logic              pred_inv,
    input logic [MAX_VL-1:0] pred_mask
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !addr_valid && !busy);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(dst_reg) && $stable(dst_elem));

    // R5
    seg_reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && addr_ready |=> !addr_valid || (dst_elem != $past(dst_elem))
            || (dst_reg == RD_W'($past(dst_reg) + 1'b1)));

    // R6
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && addr_ready |=> !addr_valid || (dst_elem >= $past(dst_elem)));

    // R6
    pred_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && pred_en |-> (pred_mask[dst_elem] ^ pred_inv));

    // R7
    elem_in_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (VL_W'(dst_elem) < vl));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy && !addr_ready |=> busy && $stable(dst_elem) && $stable(dst_reg));
endmodule

bind vld_agen vld_agen_chk #(
    .AW(AW), .MAX_VL(MAX_VL), .RD_W(RD_W), .ELEM_W(ELEM_W), .VL_W(VL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .addr_valid(addr_valid),
    .addr_ready(addr_ready),
    .addr      (addr),
    .dst_reg   (dst_reg),
    .dst_elem  (dst_elem),
    .vl        (vl),
    .pred_en   (pred_en),
    .pred_inv  (pred_inv),
    .pred_mask (pred_mask)
);

// File: tb/vld_agen_test.sv
// Bench: behavioural reference queue of expected accesses, compared on
// every clock while an access is offered.
module vld_agen_test;
    localparam int AW = 32, EB_W = 8, MAX_VL = 32, SEG_W = 3, RD_W = 5;
    localparam int ELEM_W = 5, VL_W = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] base_addr = '0, stride_val = '0, idx_offset;
    logic [EB_W-1:0] elem_bytes = '0;
    logic stride_mode = 1'b0, indexed = 1'b0, pred_en = 1'b0, pred_inv = 1'b0;
    logic [SEG_W-1:0] seg_len = '0;
    logic [VL_W-1:0] vl = '0;
    logic [RD_W-1:0] rd = '0;
    logic [MAX_VL-1:0] pred_mask = '0;
    logic busy, addr_valid, addr_ready = 1'b0;
    logic [AW-1:0] addr;
    logic [RD_W-1:0] dst_reg;
    logic [ELEM_W-1:0] dst_elem;

    logic [AW-1:0] idx_tab [MAX_VL];
    assign idx_offset = idx_tab[dst_elem];

    int checks = 0, fails = 0, cyc = 0;
    string cur_tag = "R1";
    bit mon_on = 1'b0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [AW-1:0] q_addr[$];
    int q_reg[$];
    int q_elem[$];

    always #4 clk = ~clk;

    vld_agen uut (.*);

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R10 watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // compare offered access against reference, then choose ready
    always @(negedge clk) begin
        if (mon_on) begin
            if (addr_valid) begin
                checks++;
                if (q_addr.size() == 0) begin
                    fails++;
                    $display("FAIL %s: unexpected access %h reg %0d elem %0d, expected none",
                             cur_tag, addr, dst_reg, dst_elem);
                end else if (addr !== q_addr[0] || int'(dst_reg) != q_reg[0]
                             || int'(dst_elem) != q_elem[0]) begin
                    fails++;
                    $display("FAIL %s: actual %h reg %0d elem %0d, expected %h reg %0d elem %0d",
                             cur_tag, addr, dst_reg, dst_elem, q_addr[0], q_reg[0], q_elem[0]);
                end
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            addr_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
            if (addr_valid && addr_ready && q_addr.size() > 0) begin
                void'(q_addr.pop_front());
                void'(q_reg.pop_front());
                void'(q_elem.pop_front());
            end
        end
    end

    task automatic issue(string tag, logic [AW-1:0] b, int eb, bit smode, logic [AW-1:0] sv,
                         bit idx, int sl, int v, int r, bit pe, bit pi, logic [MAX_VL-1:0] pm);
        logic [AW-1:0] st;
        cur_tag = tag;
        st = smode ? sv : AW'(eb);
        for (int i = 0; i < v; i++) begin
            if (!pe || (pm[i] ^ pi)) begin
                for (int j = 0; j <= sl; j++) begin
                    if (idx) q_addr.push_back(b + idx_tab[i] + AW'(j) * st);
                    else     q_addr.push_back(b + AW'(i * (sl + 1)) * st + AW'(j) * st);
                    q_reg.push_back((r + j) % 32);
                    q_elem.push_back(i);
                end
            end
        end
        base_addr = b; elem_bytes = EB_W'(eb); stride_mode = smode; stride_val = sv;
        indexed = idx; seg_len = SEG_W'(sl); vl = VL_W'(v); rd = RD_W'(r);
        pred_en = pe; pred_inv = pi; pred_mask = pm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_cmd(string tag);
        int guard = 0;
        @(negedge clk);
        while ((busy || q_addr.size() != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        checks++;
        if (busy !== 1'b0 || addr_valid !== 1'b0 || q_addr.size() != 0) begin
            fails++;
            $display("FAIL %s R10: actual busy %b valid %b left %0d, expected idle 0 0 0",
                     tag, busy, addr_valid, q_addr.size());
        end
    endtask

    initial begin
        for (int k = 0; k < MAX_VL; k++) idx_tab[k] = AW'((k * 37 + 5) % 211) << 2;
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || addr_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual busy %b valid %b, expected 0 0", busy, addr_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || addr_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release busy %b valid %b, expected 0 0", busy, addr_valid);
        end
        mon_on = 1'b1;

        // R2 R7 unit stride, no predicate
        issue("R2", 32'h0000_1000, 4, 1'b0, 32'h0, 1'b0, 0, 8, 3, 1'b0, 1'b0, '0);
        finish_cmd("R2");
        // R3 R5 R6 constant stride, segments, predicate
        stall_mode = 1'b1;
        issue("R3", 32'h0002_0000, 4, 1'b1, 32'd12, 1'b0, 2, 5, 8, 1'b1, 1'b0, 32'b10110);
        finish_cmd("R3");
        // R6 inverted predicate
        issue("R6", 32'h0002_0000, 4, 1'b1, 32'd12, 1'b0, 2, 5, 8, 1'b1, 1'b1, 32'b10110);
        finish_cmd("R6");
        // R4 indexed, unit stride of 8, two segments
        issue("R4", 32'h0040_0000, 8, 1'b0, 32'h0, 1'b1, 1, 6, 1, 1'b0, 1'b0, '0);
        finish_cmd("R4");
        // R4 indexed with constant stride and predicate
        issue("R4", 32'h0050_0000, 2, 1'b1, 32'd100, 1'b1, 3, 10, 4, 1'b1, 1'b0, 32'h2A5);
        finish_cmd("R4");
        // R9 R5 address wrap and register wrap past 31
        issue("R9", 32'hFFFF_FFF0, 4, 1'b1, 32'h10, 1'b0, 3, 4, 30, 1'b0, 1'b0, '0);
        finish_cmd("R9");
        // R8 full length under stalls with a sparse mask
        issue("R8", 32'h0000_8000, 1, 1'b0, 32'h0, 1'b0, 0, 32, 0, 1'b1, 1'b0, 32'h8001_F00D);
        finish_cmd("R8");
        // R7 full length, maximum segments, no predicate
        stall_mode = 1'b0;
        issue("R7", 32'h0001_0000, 4, 1'b0, 32'h0, 1'b0, 7, 32, 0, 1'b0, 1'b0, '0);
        finish_cmd("R7");
        // R10 vl zero and all-masked: nothing issued, busy stays low
        issue("R10", 32'h0000_0100, 4, 1'b0, 32'h0, 1'b0, 1, 0, 0, 1'b0, 1'b0, '0);
        finish_cmd("R10");
        issue("R10", 32'h0000_0100, 4, 1'b0, 32'h0, 1'b0, 1, 6, 0, 1'b1, 1'b1, 32'h3F);
        finish_cmd("R10");
        // R10 start while busy has no effect
        stall_mode = 1'b1;
        issue("R10", 32'h0003_0000, 4, 1'b1, 32'd24, 1'b0, 1, 9, 2, 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_cmd("R10");
        // R2 back-to-back after busy falls
        stall_mode = 1'b0;
        issue("R2", 32'h0000_0040, 2, 1'b0, 32'h0, 1'b0, 1, 3, 5, 1'b0, 1'b0, '0);
        finish_cmd("R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule